// File: doc/BRIEF.md
# Configuration Space Address/Data Port Decoder

This block sits on a port-mapped I/O bus on the host side of a configuration space and implements the two-port indirect access scheme. A 32-bit address register at port 0xCF8 selects a bus, device, function and register offset. Accesses to the four-byte data window at 0xCFC..0xCFF are then turned into single configuration read or write requests on a downstream request/response channel.

A request goes downstream only under three conditions. The enable bit of the address register must be set. The decoded bus, device and function must equal a target given on static input pins. The access size must be legal for the port used. Every other data-window access completes locally: a read returns zero and a write is discarded.

The I/O side takes one request pulse at a time. It answers with a one-cycle done pulse that carries the read data. A caller issues no new request until done has been seen.

Top module: `cfg_mech_decoder`

## Requirements
- R1: Reset clears the address register to 0. Only a write with size code 2 (dword) to port 0xCF8 loads it, and the stored value is the write data ANDed with 0x80FFFFFC. Byte or word writes to 0xCF8 leave it unchanged.
- R2: A dword read of port 0xCF8 returns the address register. A read of 0xCF8 with any other size returns 0.
- R3: When address bit 31 is clear, data-window reads return 0 and data-window writes issue no downstream request.
- R4: Address bits 23:16 are the bus, bits 15:11 the device and bits 10:8 the function. If any of them differs from the target pins, no request is issued and a read returns 0.
- R5: Byte (size code 0) and word (size code 1) accesses are taken at any port 0xCFC..0xCFF. The downstream offset is address bits 7:0 plus port bits 1:0, and the size and write data are passed through unchanged.
- R6: Dword data accesses are taken only at port 0xCFC, with offset equal to address bits 7:0. A dword access at 0xCFD..0xCFF issues no request and reads 0.
- R7: A downstream request holds its valid signal and its fields steady until ready. The I/O done pulse follows one cycle after ready. A forwarded read returns the downstream read data, and a forwarded write returns 0.
- R8: An access that completes locally (address port, dropped or ignored) raises done in the cycle after the request and issues no downstream request.
- R9: Ports 0xCF9..0xCFB, and size code 3 at any port, read 0, issue no request and leave the address register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | One-cycle I/O access request |
| io_write | input | 1 | 1 = write, 0 = read |
| io_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| io_port | input | 16 | I/O port number |
| io_wdata | input | 32 | I/O write data |
| io_rdata | output | 32 | I/O read data, valid with io_done |
| io_done | output | 1 | One-cycle completion pulse |
| tgt_bus | input | 8 | Selected bus number |
| tgt_dev | input | 5 | Selected device number |
| tgt_fn | input | 3 | Selected function number |
| dn_valid | output | 1 | Downstream request valid |
| dn_write | output | 1 | Downstream write flag |
| dn_size | output | 2 | Downstream size code |
| dn_offset | output | 8 | Downstream register offset |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ready |
| dn_ready | input | 1 | Downstream completion |

## Verification
A corrupted address register shows at the next dword read of 0xCF8. It shows sooner as a request that should not appear, or a wrong offset, in the cycle after the next data-window access. A stuck or wrong controller state shows as a done pulse that is missing or early, or a valid that drops before ready. That appears in the first cycle after the request or the ready. The sweep runs every size and port pair under enabled, disabled and each kind of target mismatch. Each of those faults therefore meets a check within one access.

// File: rtl/cfg_mech_pkg.sv
package cfg_mech_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } acc_size_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctrl_state_t;

  localparam int unsigned PORT_W   = 16;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned OFF_W    = 8;
  localparam int unsigned BUS_W    = 8;
  localparam int unsigned DEV_W    = 5;
  localparam int unsigned FN_W     = 3;
  localparam logic [31:0] ADDR_MASK = 32'h80FF_FFFC;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg #(
  parameter int unsigned       W    = 32,
  parameter logic [W-1:0]      MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] addr_q
);
  logic [W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (ld_en) addr_d = ld_data & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end
endmodule

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_mech_pkg::*;
#(
  parameter logic [PORT_W-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [PORT_W-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic [PORT_W-1:0] port,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] addr,
  input  logic [BUS_W-1:0]  tgt_bus,
  input  logic [DEV_W-1:0]  tgt_dev,
  input  logic [FN_W-1:0]   tgt_fn,
  output logic              addr_hit,
  output logic              fwd,
  output logic [OFF_W-1:0]  fwd_off
);
  localparam int unsigned LANE_W = 2;

  logic in_window, legal, enabled, match;
  logic [LANE_W-1:0] lane;

  always_comb begin
    lane      = port[LANE_W-1:0];
    in_window = (port[PORT_W-1:LANE_W] == DATA_PORT[PORT_W-1:LANE_W]);
    addr_hit  = (port == ADDR_PORT) && (size == SZ_DWORD);
    unique case (size)
      SZ_BYTE, SZ_WORD: legal = in_window;
      SZ_DWORD:         legal = (port == DATA_PORT);
      default:          legal = 1'b0;
    endcase
    enabled = addr[DATA_W-1];
    match   = (addr[23:16] == tgt_bus) && (addr[15:11] == tgt_dev) &&
              (addr[10:8] == tgt_fn);
    fwd     = legal && enabled && match;
    if (size == SZ_DWORD) fwd_off = addr[OFF_W-1:0];
    else                  fwd_off = addr[OFF_W-1:0] + OFF_W'(lane);
  end
endmodule

// File: rtl/cfg_fwd_ctrl.sv
module cfg_fwd_ctrl
  import cfg_mech_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              fwd,
  input  logic              io_write,
  input  logic [1:0]        io_size,
  input  logic [OFF_W-1:0]  fwd_off,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] local_rdata,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic              dn_ready,
  output logic              busy,
  output logic              io_done,
  output logic [DATA_W-1:0] io_rdata,
  output logic              dn_valid,
  output logic              dn_write,
  output logic [1:0]        dn_size,
  output logic [OFF_W-1:0]  dn_offset,
  output logic [DATA_W-1:0] dn_wdata
);
  ctrl_state_t       st_q, st_d;
  logic              done_d;
  logic [DATA_W-1:0] rdata_d;
  logic              req_ld;
  logic              wr_q;
  logic [1:0]        size_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] wdata_q;

  always_comb begin
    st_d    = st_q;
    done_d  = 1'b0;
    rdata_d = io_rdata;
    req_ld  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (fwd) begin
            st_d   = ST_WAIT;
            req_ld = 1'b1;
          end else begin
            done_d  = 1'b1;
            rdata_d = io_write ? '0 : local_rdata;
          end
        end
      end
      ST_WAIT: begin
        if (dn_ready) begin
          st_d    = ST_IDLE;
          done_d  = 1'b1;
          rdata_d = wr_q ? '0 : dn_rdata;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      io_done  <= 1'b0;
      io_rdata <= '0;
    end else begin
      st_q     <= st_d;
      io_done  <= done_d;
      io_rdata <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      size_q  <= '0;
      off_q   <= '0;
      wdata_q <= '0;
    end else if (req_ld) begin
      wr_q    <= io_write;
      size_q  <= io_size;
      off_q   <= fwd_off;
      wdata_q <= io_wdata;
    end
  end

  assign busy      = (st_q == ST_WAIT);
  assign dn_valid  = busy;
  assign dn_write  = wr_q;
  assign dn_size   = size_q;
  assign dn_offset = off_q;
  assign dn_wdata  = wdata_q;
endmodule

// File: rtl/cfg_mech_decoder.sv
module cfg_mech_decoder
  import cfg_mech_pkg::*;
#(
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_req,
  input  logic        io_write,
  input  logic [1:0]  io_size,
  input  logic [15:0] io_port,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        io_done,
  input  logic [7:0]  tgt_bus,
  input  logic [4:0]  tgt_dev,
  input  logic [2:0]  tgt_fn,
  output logic        dn_valid,
  output logic        dn_write,
  output logic [1:0]  dn_size,
  output logic [7:0]  dn_offset,
  output logic [31:0] dn_wdata,
  input  logic [31:0] dn_rdata,
  input  logic        dn_ready
);
  logic [DATA_W-1:0] addr_q;
  logic              addr_hit, fwd, busy, accept, addr_ld;
  logic [OFF_W-1:0]  fwd_off;
  logic [DATA_W-1:0] local_rdata;

  assign accept      = io_req && !busy;
  assign addr_ld     = accept && addr_hit && io_write;
  assign local_rdata = addr_hit ? addr_q : '0;

  cfg_addr_reg #(.W(DATA_W), .MASK(ADDR_MASK)) u_addr (
    .clk(clk), .rst_n(rst_n), .ld_en(addr_ld), .ld_data(io_wdata),
    .addr_q(addr_q)
  );

  cfg_port_decode #(.ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_dec (
    .port(io_port), .size(io_size), .addr(addr_q),
    .tgt_bus(tgt_bus), .tgt_dev(tgt_dev), .tgt_fn(tgt_fn),
    .addr_hit(addr_hit), .fwd(fwd), .fwd_off(fwd_off)
  );

  cfg_fwd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .fwd(fwd),
    .io_write(io_write), .io_size(io_size), .fwd_off(fwd_off),
    .io_wdata(io_wdata), .local_rdata(local_rdata),
    .dn_rdata(dn_rdata), .dn_ready(dn_ready), .busy(busy),
    .io_done(io_done), .io_rdata(io_rdata), .dn_valid(dn_valid),
    .dn_write(dn_write), .dn_size(dn_size), .dn_offset(dn_offset),
    .dn_wdata(dn_wdata)
  );
endmodule

// File: rtl/cfg_mech_checker.sv
module cfg_mech_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        io_req,
  input logic        io_done,
  input logic [31:0] addr_q,
  input logic [7:0]  tgt_bus,
  input logic [4:0]  tgt_dev,
  input logic [2:0]  tgt_fn,
  input logic        dn_valid,
  input logic        dn_ready,
  input logic [1:0]  dn_size,
  input logic [7:0]  dn_offset
);
  AST_ADDR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q & 32'h7F00_0003) == 32'h0);  // R1

  AST_FWD_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> addr_q[31]);  // R3

  AST_FWD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (addr_q[23:16] == tgt_bus && addr_q[15:11] == tgt_dev &&
                  addr_q[10:8] == tgt_fn));  // R4

  AST_DWORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_size == 2'd2) |-> dn_offset[1:0] == 2'd0);  // R6

  AST_NO_RSVD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> dn_size != 2'd3);  // R9

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_offset) &&
                                 $stable(dn_size)));  // R7

  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready) |=> (io_done && !dn_valid));  // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    io_done |=> !io_done);  // R8

  AST_LOCAL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !dn_valid) |=> (io_done || dn_valid));  // R8
endmodule

bind cfg_mech_decoder cfg_mech_checker u_chk (
  .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_done(io_done),
  .addr_q(addr_q), .tgt_bus(tgt_bus), .tgt_dev(tgt_dev), .tgt_fn(tgt_fn),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_size(dn_size),
  .dn_offset(dn_offset)
);

// File: tb/cfg_mech_decoder_test.sv
module cfg_mech_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_req, io_write;
  logic [1:0]  io_size;
  logic [15:0] io_port;
  logic [31:0] io_wdata, io_rdata, dn_wdata, dn_rdata;
  logic        io_done, dn_valid, dn_write, dn_ready;
  logic [1:0]  dn_size;
  logic [7:0]  dn_offset;
  localparam logic [7:0] TB_BUS = 8'h5A;
  localparam logic [4:0] TB_DEV = 5'h13;
  localparam logic [2:0] TB_FN  = 3'h5;

  int vectors = 0;
  int fails   = 0;
  logic [31:0] model_addr;

  always #2 clk = ~clk;

  cfg_mech_decoder uut (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_write(io_write),
    .io_size(io_size), .io_port(io_port), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_done(io_done), .tgt_bus(TB_BUS),
    .tgt_dev(TB_DEV), .tgt_fn(TB_FN), .dn_valid(dn_valid),
    .dn_write(dn_write), .dn_size(dn_size), .dn_offset(dn_offset),
    .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_ready(dn_ready)
  );

  function automatic logic [31:0] resp(input logic [7:0] off);
    return {8'hC3, off, ~off, off ^ 8'h5A};
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] sz, input logic [15:0] port,
                        input logic wr, input logic [31:0] wd, input int lat);
    logic        legal, en, match, fwd_exp, got_fwd, loc_done;
    logic [7:0]  off_exp, off_got;
    logic [1:0]  sz_got;
    logic        wr_got;
    logic [31:0] wd_got, rd_exp;
    int          n;
    string       tag;
    legal = (sz < 2'd2 && port[15:2] == 14'h33F) || (sz == 2'd2 && port == 16'h0CFC);
    en    = model_addr[31];
    match = model_addr[23:16] == TB_BUS && model_addr[15:11] == TB_DEV &&
            model_addr[10:8] == TB_FN;
    fwd_exp = legal && en && match;
    off_exp = (sz == 2'd2) ? model_addr[7:0] : model_addr[7:0] + {6'd0, port[1:0]};
    if (port == 16'h0CF8) tag = (wr ? "R1" : "R2");
    else if (sz == 2'd3 || (port >= 16'h0CF9 && port <= 16'h0CFB)) tag = "R9";
    else if (!legal) tag = "R6";
    else if (!en) tag = "R3";
    else if (!match) tag = "R4";
    else tag = (sz == 2'd2) ? "R6" : "R5";
    if (fwd_exp) rd_exp = wr ? 32'h0 : resp(off_exp);
    else if (!wr && port == 16'h0CF8 && sz == 2'd2) rd_exp = model_addr;
    else rd_exp = 32'h0;

    @(negedge clk);
    io_req = 1'b1; io_write = wr; io_size = sz; io_port = port; io_wdata = wd;
    @(negedge clk);
    io_req = 1'b0;
    loc_done = io_done;
    got_fwd = 1'b0; n = 0;
    off_got = '0; sz_got = '0; wr_got = 1'b0; wd_got = '0;
    while (!io_done && n < 40) begin
      if (dn_valid && !got_fwd) begin
        got_fwd = 1'b1;
        off_got = dn_offset; sz_got = dn_size; wr_got = dn_write; wd_got = dn_wdata;
        repeat (lat) @(negedge clk);
        check("R7 hold", {dn_valid, dn_offset}, {1'b1, off_got});
        dn_rdata = resp(dn_offset);
        dn_ready = 1'b1;
        @(negedge clk);
        dn_ready = 1'b0;
        dn_rdata = 32'hDEAD_BEEF;
      end else begin
        @(negedge clk);
      end
      n++;
    end
    check({tag, " forwarded"}, {31'd0, got_fwd}, {31'd0, fwd_exp});
    if (!fwd_exp) check("R8 local done next cycle", {31'd0, loc_done}, 32'd1);
    if (fwd_exp && got_fwd) begin
      check({tag, " offset"}, {24'd0, off_got}, {24'd0, off_exp});
      check({tag, " size/dir"}, {29'd0, sz_got, wr_got}, {29'd0, sz, wr});
      if (wr) check({tag, " wdata"}, wd_got, wd);
    end
    check({tag, fwd_exp ? " R7" : "", " rdata"}, io_rdata, rd_exp);
    if (wr && port == 16'h0CF8 && sz == 2'd2) model_addr = wd & 32'h80FF_FFFC;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] cfgs [6];
    rst_n = 1'b0; io_req = 1'b0; io_write = 1'b0; io_size = '0;
    io_port = '0; io_wdata = '0; dn_rdata = '0; dn_ready = 1'b0;
    model_addr = '0;
    repeat (3) @(negedge clk);
    check("R1 reset done", {31'd0, io_done}, 32'd0);
    check("R7 reset valid", {31'd0, dn_valid}, 32'd0);
    rst_n = 1'b1;
    access(2'd2, 16'h0CF8, 1'b0, 32'h0, 0);  // R1 reset value 0
    cfgs[0] = {1'b1, 7'h7F, TB_BUS, TB_DEV, TB_FN, 8'h13};
    cfgs[1] = {1'b1, 7'h00, TB_BUS, TB_DEV, TB_FN, 8'hFC};
    cfgs[2] = {1'b0, 7'h21, TB_BUS, TB_DEV, TB_FN, 8'h40};
    cfgs[3] = {1'b1, 7'h00, TB_BUS ^ 8'h01, TB_DEV, TB_FN, 8'h40};
    cfgs[4] = {1'b1, 7'h00, TB_BUS, TB_DEV ^ 5'h10, TB_FN, 8'h40};
    cfgs[5] = {1'b1, 7'h00, TB_BUS, TB_DEV, TB_FN ^ 3'h1, 8'h40};
    for (int c = 0; c < 6; c++) begin
      access(2'd2, 16'h0CF8, 1'b1, cfgs[c], 0);
      access(2'd2, 16'h0CF8, 1'b0, 32'h0, 0);  // R2 readback of masked value
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 8; p++)
          for (int w = 0; w < 2; w++)
            access(2'(s), 16'h0CF8 + 16'(p), 1'(w),
                   (16'h0CF8 + 16'(p) == 16'h0CF8 && s == 2) ?
                     (cfgs[c] ^ 32'h7F00_0003) : {16'hA0B0, 8'(p), 8'(s)},
                   (p + s + c) % 3);
      access(2'd2, 16'h0CF8, 1'b0, 32'h0, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule